// File: doc/BRIEF.md
# Retriggerable Request-Until-Acknowledge Checker

This block watches three single-bit signals and judges, cycle by cycle, the rule "whenever a trigger is seen, the request must be high and must stay high until an acknowledge arrives." Every cycle with `start` high opens an obligation. A new `start` while an obligation is already open is legal and begins a fresh evaluation. All obligations watch the same request and acknowledge, so they merge into one open flag, and a single acknowledge discharges all of them.

The verdict is combinational in the cycle it concerns. It is given as a `valid`/`pending` pair and as a two-bit status code that separates the four outcomes: failed, holds, holds strongly and pending. The until is the weak form. An acknowledge that never arrives is not a failure as long as the request stays high. The block carries no data, so it has no valid/ready stream. Every pin is a plain control or status signal.

Top module: `until_chk`

## Requirements
- R1: While `rst_n` is low, the outputs are `valid`=1, `pending`=0 and `status`=0 (holds). Reset clears the open obligation and the record of past discharges.
- R2: A cycle with `start`=1 and `req`=0 is a failure: `valid`=0 and `status`=3 in that same cycle. This holds whatever the value of `ack`.
- R3: If an obligation is open from an earlier cycle and `ack`=0, then `req`=0 in that cycle is a failure (`valid`=0, `status`=3).
- R4: In a cycle where an open obligation sees `ack`=1, the obligation is discharged and `req` is not required. `pending` is 0 in that cycle, and the obligation is no longer open in the next cycle.
- R5: `start`=1, `req`=1 and `ack`=1 in the same cycle discharge immediately: `valid`=1 and `pending`=0.
- R6: A `start` while an obligation is open is accepted without failure. A single `ack` then closes all merged obligations.
- R7: Weak until: with no `ack` and `req` held high, `valid` stays 1 and `pending` stays 1 for as many cycles as it lasts.
- R8: `pending` is 1 exactly when an obligation stays open beyond the current cycle, that is when (`start` or an already open obligation) holds and `ack`=0. A failure does not close the obligation.
- R9: `status` encoding: 0 = holds (nothing open, no discharge since reset), 1 = holds strongly (nothing open, at least one discharge since reset), 2 = pending, 3 = failed. Failed takes precedence over the other three.
- R10: With no obligation open and `start`=0, the values of `req` and `ack` have no effect on `valid` or `pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Trigger; opens an obligation in its cycle |
| req | input | 1 | Observed request operand |
| ack | input | 1 | Observed acknowledge operand |
| valid | output | 1 | 0 when the rule is broken in this cycle |
| pending | output | 1 | 1 when an obligation remains open after this cycle |
| status | output | 2 | Four-valued verdict code, see R9 |

## Verification
Several functions can fall in one cycle. A trigger can coincide with a discharge (`start` and `ack` both high), and a failure can coincide with a retrigger or with an obligation that stays open. The vector table sets up such a cycle from a known open or closed state: for example, `start` with `req` low while `ack` is high, or `start` with `req` low while nothing acknowledges. The bench then judges the failure verdict and the pending bit of that same cycle separately, and checks the state the cycle leaves behind in the cycle after it.

// File: rtl/until_chk_pkg.sv
package until_chk_pkg;
  typedef enum logic [1:0] {
    ST_HOLDS  = 2'd0,
    ST_STRONG = 2'd1,
    ST_PEND   = 2'd2,
    ST_FAIL   = 2'd3
  } until_status_e;
endpackage

// File: rtl/until_obligation.sv
// Merged obligation state: one open flag for all overlapping triggers,
// plus a sticky record that some obligation has been discharged.
module until_obligation (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack,
  output logic open_q,
  output logic next_open,
  output logic discharge,
  output logic hist_q
);
  logic active;

  always_comb begin
    active    = start | open_q;
    discharge = active & ack;
    next_open = active & ~ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      open_q <= next_open;
      if (discharge) hist_q <= 1'b1;
    end
  end
endmodule

// File: rtl/until_verdict.sv
// Combinational judgement of the current cycle.
module until_verdict
  import until_chk_pkg::*;
(
  input  logic       rst_n,
  input  logic       start,
  input  logic       req,
  input  logic       ack,
  input  logic       open_q,
  input  logic       next_open,
  input  logic       discharge,
  input  logic       hist_q,
  output logic       valid,
  output logic       pending,
  output logic [1:0] status
);
  logic          broken;
  until_status_e st;

  always_comb begin
    // a trigger demands req now; an open obligation demands req unless ack ends it
    broken = (start & ~req) | (open_q & ~ack & ~req);
    if (!rst_n)           st = ST_HOLDS;
    else if (broken)      st = ST_FAIL;
    else if (next_open)   st = ST_PEND;
    else if (hist_q | discharge) st = ST_STRONG;
    else                  st = ST_HOLDS;
    valid   = ~rst_n | ~broken;
    pending = rst_n & next_open;
    status  = st;
  end
endmodule

// File: rtl/until_chk.sv
module until_chk (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       req,
  input  logic       ack,
  output logic       valid,
  output logic       pending,
  output logic [1:0] status
);
  logic open_q, next_open, discharge, hist_q;

  until_obligation u_obl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ack       (ack),
    .open_q    (open_q),
    .next_open (next_open),
    .discharge (discharge),
    .hist_q    (hist_q)
  );

  until_verdict u_vrd (
    .rst_n     (rst_n),
    .start     (start),
    .req       (req),
    .ack       (ack),
    .open_q    (open_q),
    .next_open (next_open),
    .discharge (discharge),
    .hist_q    (hist_q),
    .valid     (valid),
    .pending   (pending),
    .status    (status)
  );
endmodule

// File: rtl/until_chk_sva.sv
module until_chk_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       req,
  input logic       ack,
  input logic       valid,
  input logic       pending,
  input logic [1:0] status
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (valid && !pending && status == 2'd0));

  // R2
  start_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !req) |-> !valid);

  // R3
  open_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pending) && !ack && !req) |-> !valid);

  // R4
  ack_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !pending);

  // R7
  weak_stays_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pending) && !ack) |-> pending);

  // R8
  start_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ack) |-> pending);

  // R9
  fail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid == (status != 2'd3)));
endmodule

bind until_chk until_chk_sva u_sva (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .req     (req),
  .ack     (ack),
  .valid   (valid),
  .pending (pending),
  .status  (status)
);

// File: tb/tb_until_chk.sv
`timescale 1ns/1ps
module tb_until_chk;
  logic       clk = 1'b0;
  logic       rst_n, start, req, ack;
  logic       valid, pending;
  logic [1:0] status;
  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  until_chk dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req(req), .ack(ack),
    .valid(valid), .pending(pending), .status(status)
  );

  // {start, req, ack, exp_valid, exp_pending, exp_status[1:0]}, walked from a fresh reset
  localparam int NV = 14;
  localparam logic [6:0] VEC [NV] = '{
    7'b000_1_0_00, // idle, holds                       R10
    7'b110_1_1_10, // open                              R8
    7'b010_1_1_10, // held                              R8
    7'b001_1_0_01, // discharge, req not needed         R4
    7'b000_1_0_01, // holds strongly                    R9
    7'b111_1_0_01, // same-cycle discharge              R5
    7'b100_0_1_11, // start w/o req fails, stays open   R2
    7'b010_1_1_10, // still open                        R8
    7'b110_1_1_10, // retrigger while open              R6
    7'b000_0_1_11, // open obligation broken            R3
    7'b001_1_0_01, // one ack closes all                R6
    7'b000_1_0_01, // req low, nothing open             R10
    7'b001_1_0_01, // stray ack, nothing open           R10
    7'b101_0_0_11  // start w/o req with ack still fails R2
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {valid,pending,status} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic r, input logic a);
    @(negedge clk);
    start = s; req = r; ack = a;
    #3;
  endtask

  initial begin
    #(200000 * 8);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; req = 1'b0; ack = 1'b0;
    #3;
    check("R1 reset state", {valid, pending, status}, 4'b1000);
    // request inputs during reset do not leak out
    drive(1'b1, 1'b0, 1'b0);
    check("R1 inputs ignored in reset", {valid, pending, status}, 4'b1000);
    drive(1'b0, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][6], VEC[i][5], VEC[i][4]);
      check($sformatf("vector %0d (R2..R10 table)", i), {valid, pending, status}, VEC[i][3:0]);
    end

    // R7: weak until, long wait with req high
    drive(1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 40; k++) begin
      drive(1'b0, 1'b1, 1'b0);
      if (k % 8 == 0) check("R7 open without ack", {valid, pending, status}, 4'b1110);
    end

    // R1: reset in the middle of an open obligation clears it and the history
    @(negedge clk); rst_n = 1'b0; start = 1'b0; req = 1'b0; ack = 1'b0;
    #3;
    check("R1 reset while open", {valid, pending, status}, 4'b1000);
    @(negedge clk); rst_n = 1'b1;
    drive(1'b0, 1'b0, 1'b0);
    check("R1 open flag cleared (req low no fail)", {valid, pending, status}, 4'b1000);

    // R5 from clean state sets strong history
    drive(1'b1, 1'b1, 1'b1);
    check("R5 immediate discharge", {valid, pending, status}, 4'b1001);
    drive(1'b0, 1'b0, 1'b0);
    check("R9 strong after discharge", {valid, pending, status}, 4'b1001);

    // R3/R8: failure keeps obligation open, then ack closes it
    drive(1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b0);
    check("R3 broken obligation", {valid, pending, status}, 4'b0111);
    drive(1'b0, 1'b1, 1'b0);
    check("R8 still open after fail", {valid, pending, status}, 4'b1110);
    drive(1'b0, 1'b0, 1'b1);
    check("R4 ack discharges", {valid, pending, status}, 4'b1001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule